// File: doc/BRIEF.md
# Block-Granular Memory Security Filter

This block sits in front of a memory and decides, for every incoming transfer, whether that transfer may reach the memory. The memory is divided into equal blocks. A table holds one bit per block: a set bit marks the block non-secure and a clear bit marks it secure. A non-secure transfer that hits a secure block is a violation. The filter answers a violation with either a bus error or a read-as-zero/write-ignored response, and it raises an interrupt flag.

Software reaches the table through an indexed window. It writes a word index, then reads or writes a data register, and it can make the index advance by itself after each access. A control bit locks the whole configuration until the next reset. In the gating layout, a request bit stops new traffic from reaching the memory. The block raises an acknowledge once nothing sent to the memory is still outstanding. Transfers that arrive while gated are either stalled or refused with an error.

Top module: `mpc_filter`

## Requirements
- R1: The block size is 2^(BLK_CFG+5) bytes and the block-config register (select 2) reads BLK_CFG. A transfer address maps to block n = addr >> (BLK_CFG+5), and the state of block n is bit n%32 of table word n/32.
- R2: Table word k is reached by writing k to the index register (select 3) and then accessing the window register (select 4). The max-index register (select 1) reads NWORDS-1. An index of NWORDS or more reads the window as zero and ignores window writes.
- R3: When control bit 8 is set, every window read strobe or accepted window write advances the index by one.
- R4: A non-secure transfer to a block whose bit is 0 is a violation and never reaches the memory (mem_req low). A non-secure transfer to a block whose bit is 1, and any secure transfer, reaches the memory in the cycle it is accepted.
- R5: On a violation, control bit 4 picks the response, given one cycle after acceptance with rsp_valid. When the bit is 1 the response is rsp_err. When it is 0 the response is rsp_zero: the data reads as zero and the write is dropped. rsp_err and rsp_zero are never both high.
- R6: A violation sets the interrupt status bit 0 (select 5). irq equals status AND enable bit 0 (select 6). Writing 1 to bit 0 of the clear register (select 7) clears the status, and a violation in the same cycle wins.
- R7: In the gating layout, control bit 6 requests gating and no transfer reaches the memory while it is set. With control bit 16 at 0, xfer_ready is low. With bit 16 at 1, transfers are accepted and answered with rsp_err.
- R8: Control bit 7 (the acknowledge, read-only) rises the cycle after the request is set and no memory transfer is outstanding, and falls within two cycles of the request being released.
- R9: Once control bit 31 is set, writes to the control, index and window registers are ignored until reset.
- R10: After reset the table is all zeros and the status, enable and control bits are zero. Identification register (select 8) reads 0x65 in its low byte in the gating layout and 0x60 otherwise. Control bit 23 reads 1 only in the gating layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the index on window reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_addr | input | ADDR_W | Transfer byte address |
| xfer_nonsec | input | 1 | Transfer carries the non-secure attribute |
| xfer_ready | output | 1 | Transfer accepted this cycle when high with xfer_valid |
| mem_req | output | 1 | Transfer forwarded to the memory |
| rsp_valid | output | 1 | Filter response for the transfer accepted the cycle before |
| rsp_err | output | 1 | Response is a bus error |
| rsp_zero | output | 1 | Response is read-as-zero/write-ignored |
| irq | output | 1 | Violation interrupt |

## Verification
A wrong table bit or a wrong block-index decode shows up at mem_req in the same cycle as the affected transfer, and the wrong response kind shows up on rsp_err or rsp_zero one cycle later. Faults in the index register and its auto-advance show up as wrong words on the next window read. A stuck lock or a wrong gating state appears as a control readback that differs, or as xfer_ready behaving differently, immediately. A stale acknowledge appears in control bit 7 within two cycles.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;

    typedef enum logic [3:0] {
        SEL_CTRL   = 4'd0,
        SEL_MAXIDX = 4'd1,
        SEL_BLKCFG = 4'd2,
        SEL_INDEX  = 4'd3,
        SEL_WINDOW = 4'd4,
        SEL_ISTAT  = 4'd5,
        SEL_IEN    = 4'd6,
        SEL_ICLR   = 4'd7,
        SEL_IDENT  = 4'd8
    } reg_sel_e;

    localparam int CB_RESP  = 4;
    localparam int CB_GREQ  = 6;
    localparam int CB_GACK  = 7;
    localparam int CB_AINC  = 8;
    localparam int CB_GRESP = 16;
    localparam int CB_GPRES = 23;
    localparam int CB_LOCK  = 31;

    localparam logic [7:0] VER_PLAIN = 8'h60;
    localparam logic [7:0] VER_GATED = 8'h65;

    typedef struct packed {
        logic resp_err;
        logic gate_req;
        logic gate_err;
        logic auto_inc;
        logic lock;
    } ctrl_t;

    typedef struct packed {
        logic to_mem;
        logic bus_err;
        logic raz;
        logic viol;
    } verdict_t;

    function automatic logic [31:0] ctrl_word(ctrl_t c, logic ack, logic present);
        logic [31:0] w;
        w           = '0;
        w[CB_RESP]  = c.resp_err;
        w[CB_GREQ]  = c.gate_req;
        w[CB_GACK]  = ack;
        w[CB_AINC]  = c.auto_inc;
        w[CB_GRESP] = c.gate_err;
        w[CB_GPRES] = present;
        w[CB_LOCK]  = c.lock;
        return w;
    endfunction

endpackage

// File: rtl/mpc_regs.sv
`timescale 1ns/1ps
module mpc_regs
    import mpc_pkg::*;
#(
    parameter int NWORDS  = 4,
    parameter int BLK_CFG = 3,
    parameter bit GATING  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  viol_i,
    input  logic                  gate_ack_i,
    output ctrl_t                 ctrl_o,
    output logic [NWORDS*32-1:0]  lut_o,
    output logic                  istat_o,
    output logic                  irq_o
);
    localparam int IDX_W  = $clog2(NWORDS) + 2;
    localparam int WSEL_W = $clog2(NWORDS);
    localparam logic [7:0] VERSION = GATING ? VER_GATED : VER_PLAIN;

    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       lut_q [NWORDS];
    logic              istat_q, ien_q;
    logic              wr_ok, in_range, win_wr, win_step;
    logic [31:0]       win_word;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_ok    = reg_wr && !ctrl_q.lock;
    assign in_range = idx_q < IDX_W'(NWORDS);
    assign win_wr   = wr_ok && sel == SEL_WINDOW;
    assign win_step = ctrl_q.auto_inc && sel == SEL_WINDOW && (reg_rd || win_wr);
    assign win_word = in_range ? lut_q[idx_q[WSEL_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            idx_q  <= '0;
        end else begin
            if (wr_ok && sel == SEL_CTRL) begin
                ctrl_q.resp_err <= reg_wdata[CB_RESP];
                ctrl_q.auto_inc <= reg_wdata[CB_AINC];
                ctrl_q.lock     <= reg_wdata[CB_LOCK];
                if (GATING) begin
                    ctrl_q.gate_req <= reg_wdata[CB_GREQ];
                    ctrl_q.gate_err <= reg_wdata[CB_GRESP];
                end
            end
            if (wr_ok && sel == SEL_INDEX)
                idx_q <= reg_wdata[IDX_W-1:0];
            else if (win_step)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < NWORDS; w++) begin
            if (rst)
                lut_q[w] <= '0;
            else if (win_wr && idx_q == IDX_W'(w))
                lut_q[w] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            istat_q <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            if (viol_i)
                istat_q <= 1'b1;
            else if (reg_wr && sel == SEL_ICLR && reg_wdata[0])
                istat_q <= 1'b0;
            if (reg_wr && sel == SEL_IEN)
                ien_q <= reg_wdata[0];
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_flat
        assign lut_o[g*32 +: 32] = lut_q[g];
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:   reg_rdata = ctrl_word(ctrl_q, gate_ack_i, GATING);
            SEL_MAXIDX: reg_rdata = 32'(NWORDS - 1);
            SEL_BLKCFG: reg_rdata = 32'(BLK_CFG);
            SEL_INDEX:  reg_rdata = 32'(idx_q);
            SEL_WINDOW: reg_rdata = win_word;
            SEL_ISTAT:  reg_rdata = {31'd0, istat_q};
            SEL_IEN:    reg_rdata = {31'd0, ien_q};
            SEL_IDENT:  reg_rdata = {24'd0, VERSION};
            default:    reg_rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign istat_o = istat_q;
    assign irq_o   = istat_q && ien_q;
endmodule

// File: rtl/mpc_access.sv
`timescale 1ns/1ps
module mpc_access
    import mpc_pkg::*;
#(
    parameter int NWORDS  = 4,
    parameter int BLK_CFG = 3,
    parameter int ADDR_W  = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ctrl_t                 ctrl_i,
    input  logic [NWORDS*32-1:0]  lut_i,
    input  logic                  xfer_valid,
    input  logic [ADDR_W-1:0]     xfer_addr,
    input  logic                  xfer_nonsec,
    output logic                  xfer_ready,
    output logic                  mem_req,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic                  rsp_zero,
    output logic                  viol_o,
    output logic                  gate_ack_o,
    output logic                  inflight_o
);
    localparam int BLK_W = $clog2(NWORDS * 32);

    logic [BLK_W-1:0] blk;
    logic             blk_ns, accept, gated;
    verdict_t         v;
    logic             rsp_valid_q, rsp_err_q, rsp_zero_q, inflight_q, ack_q;

    assign blk        = xfer_addr[ADDR_W-1 -: BLK_W];
    assign blk_ns     = lut_i[blk];
    assign gated      = ctrl_i.gate_req;
    assign xfer_ready = !(gated && !ctrl_i.gate_err);
    assign accept     = xfer_valid && xfer_ready;

    always_comb begin
        v = '0;
        if (gated)
            v.bus_err = 1'b1;
        else if (xfer_nonsec && !blk_ns) begin
            v.viol    = 1'b1;
            v.bus_err = ctrl_i.resp_err;
            v.raz     = !ctrl_i.resp_err;
        end else
            v.to_mem = 1'b1;
    end

    assign mem_req = accept && v.to_mem;
    assign viol_o  = accept && v.viol;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_zero_q  <= 1'b0;
            inflight_q  <= 1'b0;
            ack_q       <= 1'b0;
        end else begin
            rsp_valid_q <= accept;
            rsp_err_q   <= accept && v.bus_err;
            rsp_zero_q  <= accept && v.raz;
            inflight_q  <= mem_req;
            ack_q       <= gated && !inflight_q;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_zero   = rsp_zero_q;
    assign inflight_o = inflight_q;
    assign gate_ack_o = ack_q;
endmodule

// File: rtl/mpc_filter.sv
`timescale 1ns/1ps
module mpc_filter
    import mpc_pkg::*;
#(
    parameter int NWORDS  = 4,
    parameter int BLK_CFG = 3,
    parameter bit GATING  = 1'b1,
    localparam int ADDR_W = $clog2(NWORDS * 32) + BLK_CFG + 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              xfer_nonsec,
    output logic              xfer_ready,
    output logic              mem_req,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_zero,
    output logic              irq
);
    ctrl_t                ctrl;
    logic [NWORDS*32-1:0] lut;
    logic                 viol, gate_ack, inflight, istat;
    logic                 lock_w, gate_req_w;

    mpc_regs #(.NWORDS(NWORDS), .BLK_CFG(BLK_CFG), .GATING(GATING)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .viol_i(viol), .gate_ack_i(gate_ack),
        .ctrl_o(ctrl), .lut_o(lut), .istat_o(istat), .irq_o(irq)
    );

    mpc_access #(.NWORDS(NWORDS), .BLK_CFG(BLK_CFG), .ADDR_W(ADDR_W)) u_access (
        .clk(clk), .rst(rst),
        .ctrl_i(ctrl), .lut_i(lut),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_nonsec(xfer_nonsec),
        .xfer_ready(xfer_ready), .mem_req(mem_req),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_zero(rsp_zero),
        .viol_o(viol), .gate_ack_o(gate_ack), .inflight_o(inflight)
    );

    assign lock_w     = ctrl.lock;
    assign gate_req_w = ctrl.gate_req;
endmodule

// File: rtl/mpc_filter_sva.sv
`timescale 1ns/1ps
module mpc_filter_sva (
    input logic clk,
    input logic rst,
    input logic lock,
    input logic gate_req,
    input logic gate_ack,
    input logic inflight,
    input logic mem_req,
    input logic viol,
    input logic istat,
    input logic rsp_valid,
    input logic rsp_err,
    input logic rsp_zero
);
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    assert_gate_blocks_mem_R7: assert property (@(posedge clk) disable iff (rst)
        gate_req |-> !mem_req);

    assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        gate_ack |-> ($past(gate_req) && !$past(inflight)));

    assert_viol_sets_status_R6: assert property (@(posedge clk) disable iff (rst)
        viol |=> istat);

    assert_viol_no_mem_R4: assert property (@(posedge clk) disable iff (rst)
        viol |-> !mem_req);

    assert_rsp_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(rsp_err && rsp_zero));

    assert_rsp_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_err || rsp_zero) |-> rsp_valid);

    assert_zero_not_sent_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_zero |-> !$past(mem_req));
endmodule

bind mpc_filter mpc_filter_sva u_sva (
    .clk(clk), .rst(rst), .lock(lock_w), .gate_req(gate_req_w),
    .gate_ack(gate_ack), .inflight(inflight), .mem_req(mem_req),
    .viol(viol), .istat(istat), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_zero(rsp_zero)
);

// File: tb/mpc_filter_tb.sv
`timescale 1ns/1ps
module mpc_filter_tb;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          xfer_valid = 1'b0;
    logic [AW-1:0] xfer_addr = '0;
    logic          xfer_nonsec = 1'b0;
    logic          xfer_ready, mem_req, rsp_valid, rsp_err, rsp_zero, irq;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mpc_filter u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_nonsec(xfer_nonsec), .xfer_ready(xfer_ready),
        .mem_req(mem_req), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_zero(rsp_zero), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic ns,
                        output logic rdy, output logic mem,
                        output logic rv, output logic re, output logic rz);
        @(negedge clk);
        xfer_addr = a; xfer_nonsec = ns; xfer_valid = 1'b1;
        #1 rdy = xfer_ready; mem = mem_req;
        @(posedge clk);
        #1 rv = rsp_valid; re = rsp_err; rz = rsp_zero;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(4'd8, d); check("R10 ident", d & 32'hFF, 32'h65);
        reg_read(4'd0, d); check("R10 ctrl reset", d, 32'h0080_0000);
        reg_read(4'd5, d); check("R10 status reset", d, 0);
        reg_read(4'd4, d); check("R10 table word0 reset", d, 0);
        reg_read(4'd1, d); check("R2 max index", d, 3);
        reg_read(4'd2, d); check("R1 block config", d, 3);
        check("R6 irq reset", {31'd0, irq}, 0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        reg_write(4'd3, 2);
        reg_write(4'd4, 32'hA5A5_0F0F);
        reg_write(4'd3, 2);
        reg_read(4'd4, d); check("R2 window readback", d, 32'hA5A5_0F0F);
        reg_read(4'd3, d); check("R3 no advance when bit8 clear", d, 2);
    endtask

    task automatic t_autoinc();
        logic [31:0] d;
        logic [31:0] pat [4];
        pat[0] = 32'h0000_00F0; pat[1] = 32'hFFFF_0000;
        pat[2] = 32'h0000_0001; pat[3] = 32'h8000_0000;
        reg_write(4'd0, 32'h100);
        reg_write(4'd3, 0);
        for (int i = 0; i < 4; i++) reg_write(4'd4, pat[i]);
        reg_read(4'd3, d); check("R3 index after writes", d, 4);
        reg_read(4'd4, d); check("R2 out-of-range window reads zero", d, 0);
        reg_write(4'd3, 0);
        for (int i = 0; i < 4; i++) begin
            reg_read(4'd4, d); check("R3 auto-advance readback", d, pat[i]);
        end
        reg_read(4'd3, d); check("R3 index after reads", d, 4);
    endtask

    task automatic t_access();
        logic rdy, mem, rv, re, rz;
        logic [31:0] d;
        xfer(15'h0500, 1'b1, rdy, mem, rv, re, rz);
        check("R4 ns to ns block 5 sent", {rdy, mem, rv, re, rz}, 5'b11100);
        xfer(15'h3000, 1'b1, rdy, mem, rv, re, rz);
        check("R1 block 48 word1 bit16 sent", {rdy, mem, rv, re, rz}, 5'b11100);
        xfer(15'h7F00, 1'b1, rdy, mem, rv, re, rz);
        check("R1 block 127 word3 bit31 sent", {rdy, mem, rv, re, rz}, 5'b11100);
        xfer(15'h0000, 1'b0, rdy, mem, rv, re, rz);
        check("R4 secure to secure block sent", {rdy, mem, rv, re, rz}, 5'b11100);
        reg_read(4'd5, d); check("R6 no status without violation", d, 0);
        xfer(15'h2F00, 1'b1, rdy, mem, rv, re, rz);
        check("R5 violation read-as-zero", {rdy, mem, rv, re, rz}, 5'b10101);
        reg_read(4'd5, d); check("R6 status set", d, 1);
        check("R6 irq masked", {31'd0, irq}, 0);
        reg_write(4'd6, 1);
        #1 check("R6 irq enabled", {31'd0, irq}, 1);
        reg_write(4'd7, 1);
        #1 check("R6 irq cleared", {31'd0, irq}, 0);
        reg_read(4'd5, d); check("R6 status cleared", d, 0);
        reg_write(4'd0, 32'h110);
        xfer(15'h0000, 1'b1, rdy, mem, rv, re, rz);
        check("R5 violation bus error", {rdy, mem, rv, re, rz}, 5'b10110);
        #1 check("R6 irq on second violation", {31'd0, irq}, 1);
        reg_write(4'd7, 1);
    endtask

    task automatic t_gating();
        logic rdy, mem, rv, re, rz;
        logic [31:0] d;
        reg_write(4'd0, 32'h040);
        xfer(15'h0500, 1'b1, rdy, mem, rv, re, rz);
        check("R7 stall while gated", {rdy, mem, rv, re, rz}, 5'b00000);
        reg_read(4'd0, d); check("R8 ack raised", d, 32'h0080_00C0);
        reg_write(4'd0, 32'h1_0040);
        xfer(15'h0500, 1'b1, rdy, mem, rv, re, rz);
        check("R7 error while gated", {rdy, mem, rv, re, rz}, 5'b10110);
        reg_write(4'd0, 32'h0);
        @(negedge clk);
        reg_read(4'd0, d); check("R8 ack released", d, 32'h0080_0000);
        xfer(15'h0500, 1'b1, rdy, mem, rv, re, rz);
        check("R7 traffic resumes", {rdy, mem, rv, re, rz}, 5'b11100);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        reg_write(4'd3, 2);
        reg_write(4'd0, 32'h8000_0100);
        reg_read(4'd0, d); check("R9 lock set", d, 32'h8080_0100);
        reg_write(4'd0, 32'h0);
        reg_read(4'd0, d); check("R9 ctrl write ignored", d, 32'h8080_0100);
        reg_write(4'd3, 0);
        reg_read(4'd3, d); check("R9 index write ignored", d, 2);
        reg_read(4'd4, d); check("R9 window read word2", d, 1);
        reg_write(4'd4, 32'hDEAD_BEEF);
        reg_read(4'd3, d); check("R9 index after locked write", d, 3);
        reg_read(4'd4, d); check("R9 word3 unchanged", d, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_window();
        t_autoinc();
        t_access();
        t_gating();
        t_lock();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule